// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block keeps an inverted page table on chip and searches it. The table has exactly one entry per physical page frame. An entry's position in the table is its frame number, so the frame is never stored as a field. The page number alone cannot index such a table. A lookup therefore presents the pair (process ID, virtual page number). The page number is folded by a hash into a slot of an anchor table, and that slot holds the head of a collision chain. Every mapping whose page number folds to the same slot is linked into that one chain.

A lookup is accepted through a valid/ready handshake. The block then walks the chain, comparing one linked entry per clock cycle against the key. It stops at the first match, or when it reaches the reserved null pointer that ends every chain. The result is a one-cycle response carrying a hit flag and the frame index, ready to be handed to a translation cache.

A second handshake port inserts a mapping. It writes the key into the named frame's entry, links that entry in front of the current chain head, and makes it the new head. Frames are only ever added, never removed, and an insert must name a frame that is not already linked. The frame count must be a power of two.

Top module: `ipt_hash_lookup`

## Requirements
- R1: After reset `lkReady` and `insReady` are 1 and `rspValid` is 0. Every anchor slot is empty, so any lookup issued before an insert misses.
- R2: The anchor slot of a page is bits [HASH_W-1:0] of (page[9:0] XOR page[19:10]) for the default 20-bit page. Pages that share a slot share one chain, even when their page numbers differ.
- R3: An entry matches only when both its process ID and its page number equal the key. The same page under another process ID misses.
- R4: On a hit, `rspHit` is 1 and `rspFrame` equals the frame index that was given when that mapping was inserted.
- R5: A lookup accepted at clock edge E whose match sits at position k of its chain (the head is position 0) raises `rspValid` in the cycle after edge E+k.
- R6: A lookup whose chain holds L entries and none of them match gives `rspValid` = 1 and `rspHit` = 0 in the cycle after edge E+L. This means one cycle when the slot is empty.
- R7: An accepted insert places its frame at position 0 of its chain. The former head moves to position 1, so the most recent insert of a key is the one that is found.
- R8: While a search is in progress, `lkReady` and `insReady` are both 0.
- R9: When the block is idle and `insValid` and `lkValid` are both 1 in the same cycle, the insert is accepted and `lkReady` is 0. The lookup is accepted in the next cycle and sees the new mapping.
- R10: `rspValid` lasts exactly one cycle. `lkReady` is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkReady | output | 1 | Lookup can be accepted this cycle |
| lkPid | input | PID_W | Lookup process ID |
| lkVpn | input | VPN_W | Lookup virtual page number |
| insValid | input | 1 | Insert request present |
| insReady | output | 1 | Insert can be accepted this cycle |
| insPid | input | PID_W | Process ID of the new mapping |
| insVpn | input | VPN_W | Page number of the new mapping |
| insFrame | input | log2(NUM_FRAMES) | Frame that receives the new mapping |
| rspValid | output | 1 | One-cycle lookup result strobe |
| rspHit | output | 1 | Lookup found its key |
| rspFrame | output | log2(NUM_FRAMES) | Frame index of the match, meaningful when rspHit is 1 |

## Verification
An insert and a lookup can both be requested in the same idle cycle. The insert is the one accepted, and it changes the very chain the held-back lookup will search. The bench raises both valids on one falling edge, with the lookup key equal to the key being inserted. It checks that only `insReady` is high. After it drops the insert, it expects the lookup to be taken on the next edge and to hit the new frame at chain position 0 with a one-cycle latency. Random inserts concentrated on four anchor slots build long chains. Random lookups are then judged against a bench chain model for hit, frame and exact latency.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // Strobes from the walk control to the table datapath
  typedef struct packed {
    logic insWrite;  // write entry and relink chain head
    logic keyLoad;   // latch lookup key and fetch chain head
    logic advance;   // follow next pointer of current entry
  } dpCtrl_t;

  // Status returned by the datapath
  typedef struct packed {
    logic atNull;    // current pointer is the chain terminator
    logic isMatch;   // current entry matches the latched key
  } dpStat_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walkState_t;

endpackage

// File: rtl/ipt_datapath.sv
module ipt_datapath
  import ipt_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  parameter int PID_W      = 8,
  parameter int VPN_W      = 20,
  parameter int HASH_W     = 6,
  localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtrl_t            ctrl,
  input  logic [PID_W-1:0]   lkPid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [PID_W-1:0]   insPid,
  input  logic [VPN_W-1:0]   insVpn,
  input  logic [FRAME_W-1:0] insFrame,
  output dpStat_t            stat,
  output logic [FRAME_W-1:0] curFrame
);

  localparam int PTR_W     = FRAME_W + 1;
  localparam int NUM_SLOTS = 1 << HASH_W;
  localparam int LO_W      = VPN_W / 2;
  localparam logic [PTR_W-1:0] NULL_PTR = PTR_W'(NUM_FRAMES);
  localparam logic [VPN_W-1:0] LOW_MASK = (VPN_W'(1) << LO_W) - VPN_W'(1);

  // Fold the page number: low half XOR high half, then truncate
  function automatic logic [HASH_W-1:0] hashVpn(input logic [VPN_W-1:0] v);
    logic [VPN_W-1:0] folded;
    folded = (v & LOW_MASK) ^ (v >> LO_W);
    return folded[HASH_W-1:0];
  endfunction

  logic               entValid [NUM_FRAMES];
  logic [PID_W-1:0]   entPid   [NUM_FRAMES];
  logic [VPN_W-1:0]   entVpn   [NUM_FRAMES];
  logic [PTR_W-1:0]   entNext  [NUM_FRAMES];
  logic [PTR_W-1:0]   headPtr  [NUM_SLOTS];

  logic [PID_W-1:0]   keyPid;
  logic [VPN_W-1:0]   keyVpn;
  logic [PTR_W-1:0]   curPtr;

  logic [HASH_W-1:0]  insHash;
  logic [HASH_W-1:0]  lkHash;
  logic [PTR_W-1:0]   insHeadOld;
  logic [FRAME_W-1:0] curIdx;

  assign insHash    = hashVpn(insVpn);
  assign lkHash     = hashVpn(lkVpn);
  assign insHeadOld = headPtr[insHash];
  assign curIdx     = curPtr[FRAME_W-1:0];
  assign curFrame   = curIdx;

  // Entry storage and chain anchors
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        entValid[i] <= 1'b0;
        entPid[i]   <= '0;
        entVpn[i]   <= '0;
        entNext[i]  <= NULL_PTR;
      end
      for (int s = 0; s < NUM_SLOTS; s++) begin
        headPtr[s] <= NULL_PTR;
      end
    end else if (ctrl.insWrite) begin
      entValid[insFrame] <= 1'b1;
      entPid[insFrame]   <= insPid;
      entVpn[insFrame]   <= insVpn;
      entNext[insFrame]  <= insHeadOld;
      headPtr[insHash]   <= {1'b0, insFrame};
    end
  end

  // Search key and walk pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyPid <= '0;
      keyVpn <= '0;
      curPtr <= NULL_PTR;
    end else if (ctrl.keyLoad) begin
      keyPid <= lkPid;
      keyVpn <= lkVpn;
      curPtr <= headPtr[lkHash];
    end else if (ctrl.advance) begin
      curPtr <= entNext[curIdx];
    end
  end

  // Only the terminator carries the top pointer bit
  assign stat.atNull  = curPtr[PTR_W-1];
  assign stat.isMatch = !curPtr[PTR_W-1] && entValid[curIdx] &&
                        (entPid[curIdx] == keyPid) && (entVpn[curIdx] == keyVpn);

  // R7: an insert becomes the head of its slot
  p_head_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.insWrite |=> (headPtr[$past(insHash)] == {1'b0, $past(insFrame)}));

  // R7: the former head becomes second in the chain
  p_link_prev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.insWrite |=> (entNext[$past(insFrame)] == $past(insHeadOld)));

  // R6: the walk never steps past a terminator
  p_advance_nonnull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.advance |-> !stat.atNull);

endmodule

// File: rtl/ipt_control.sv
module ipt_control
  import ipt_pkg::*;
#(
  parameter int NUM_FRAMES = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lkValid,
  input  logic    insValid,
  input  dpStat_t stat,
  output logic    lkReady,
  output logic    insReady,
  output dpCtrl_t ctrl,
  output logic    rspValid,
  output logic    rspHit
);

  localparam int CNT_W = $clog2(NUM_FRAMES + 2);

  walkState_t state, stateNxt;
  logic walking;
  logic [CNT_W-1:0] walkCnt;

  assign walking  = (state == ST_WALK);
  assign insReady = !walking;
  assign lkReady  = !walking && !insValid;  // insert takes precedence

  assign ctrl.insWrite = insValid && insReady;
  assign ctrl.keyLoad  = lkValid && lkReady;
  assign ctrl.advance  = walking && !stat.atNull && !stat.isMatch;

  assign rspValid = walking && (stat.atNull || stat.isMatch);
  assign rspHit   = walking && stat.isMatch;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (ctrl.keyLoad) stateNxt = ST_WALK;
      ST_WALK: if (rspValid)     stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  // Cycles spent in the current walk, for the bound check
  always_ff @(posedge clk) begin
    if (!rst_n || !walking) walkCnt <= '0;
    else                    walkCnt <= walkCnt + CNT_W'(1);
  end

  // R5: an accepted lookup starts a walk on the next cycle
  p_accept_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.keyLoad |=> walking);

  // R10: the response is a single-cycle pulse
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R6: a chain holds at most NUM_FRAMES entries, so a walk ends in time
  p_walk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> (walkCnt <= CNT_W'(NUM_FRAMES)));

endmodule

// File: rtl/ipt_hash_lookup.sv
module ipt_hash_lookup
  import ipt_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  parameter int PID_W      = 8,
  parameter int VPN_W      = 20,
  parameter int HASH_W     = 6,
  localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lkValid,
  output logic               lkReady,
  input  logic [PID_W-1:0]   lkPid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic               insValid,
  output logic               insReady,
  input  logic [PID_W-1:0]   insPid,
  input  logic [VPN_W-1:0]   insVpn,
  input  logic [FRAME_W-1:0] insFrame,
  output logic               rspValid,
  output logic               rspHit,
  output logic [FRAME_W-1:0] rspFrame
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  ipt_control #(
    .NUM_FRAMES(NUM_FRAMES)
  ) u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .lkValid  (lkValid),
    .insValid (insValid),
    .stat     (stat),
    .lkReady  (lkReady),
    .insReady (insReady),
    .ctrl     (ctrl),
    .rspValid (rspValid),
    .rspHit   (rspHit)
  );

  ipt_datapath #(
    .NUM_FRAMES(NUM_FRAMES),
    .PID_W     (PID_W),
    .VPN_W     (VPN_W),
    .HASH_W    (HASH_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .lkPid    (lkPid),
    .lkVpn    (lkVpn),
    .insPid   (insPid),
    .insVpn   (insVpn),
    .insFrame (insFrame),
    .stat     (stat),
    .curFrame (rspFrame)
  );

  // R8: no handshake is offered while a lookup is being answered
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid) |-> (!lkReady && !insReady));

endmodule

// File: tb/test_ipt_hash_lookup.sv
`timescale 1ns/1ps
module test_ipt_hash_lookup;
  localparam int NF = 64;
  localparam int PW = 8;
  localparam int VW = 20;
  localparam int HW = 6;
  localparam int FW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic lkValid, lkReady, insValid, insReady;
  logic [PW-1:0] lkPid, insPid;
  logic [VW-1:0] lkVpn, insVpn;
  logic [FW-1:0] insFrame, rspFrame;
  logic rspValid, rspHit;

  ipt_hash_lookup #(.NUM_FRAMES(NF), .PID_W(PW), .VPN_W(VW), .HASH_W(HW)) i_ipt_hash_lookup (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkReady(lkReady), .lkPid(lkPid), .lkVpn(lkVpn),
    .insValid(insValid), .insReady(insReady), .insPid(insPid), .insVpn(insVpn),
    .insFrame(insFrame),
    .rspValid(rspValid), .rspHit(rspHit), .rspFrame(rspFrame)
  );

  int checks = 0;
  int failures = 0;

  int mHead [64];
  int mNext [NF];
  int mPid  [NF];
  int mVpn  [NF];
  bit mUsed [NF];

  function automatic int refHash(int v);
    return ((v & 'h3ff) ^ ((v >> 10) & 'h3ff)) & 'h3f;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelInsert(int pid, int vpn, int fr);
    int h;
    h = refHash(vpn);
    mNext[fr] = mHead[h];
    mHead[h]  = fr;
    mPid[fr]  = pid;
    mVpn[fr]  = vpn;
    mUsed[fr] = 1'b1;
  endtask

  task automatic modelLookup(int pid, int vpn, output bit hit, output int fr, output int lat);
    int p, k;
    p = mHead[refHash(vpn)];
    k = 0;
    hit = 1'b0; fr = 0;
    while (p != -1) begin
      if (mPid[p] == pid && mVpn[p] == vpn) begin
        hit = 1'b1; fr = p;
        break;
      end
      p = mNext[p];
      k++;
    end
    lat = k + 1;
  endtask

  task automatic doInsert(int pid, int vpn, int fr);
    @(negedge clk);
    insValid = 1'b1; insPid = PW'(pid); insVpn = VW'(vpn); insFrame = FW'(fr);
    #1;
    chk("R7", "insReady when idle", int'(insReady), 1);
    @(posedge clk);
    @(negedge clk);
    insValid = 1'b0;
    modelInsert(pid, vpn, fr);
  endtask

  // Waits for the response after an accept edge and judges it
  task automatic awaitResponse(string req, int pid, int vpn);
    bit eHit; int eFr, eLat, lat;
    modelLookup(pid, vpn, eHit, eFr, eLat);
    lat = 1;
    while (!rspValid && lat < 200) begin
      chk("R8", "readys low while searching", int'(lkReady || insReady), 0);
      @(negedge clk);
      lat++;
    end
    chk(req, "rspValid", int'(rspValid), 1);
    chk(req, "rspHit", int'(rspHit), int'(eHit));
    if (eHit) chk("R4", "rspFrame", int'(rspFrame), eFr);
    chk("R5", "latency", lat, eLat);
    @(negedge clk);
    chk("R10", "rspValid one cycle", int'(rspValid), 0);
    chk("R10", "lkReady back", int'(lkReady), 1);
  endtask

  task automatic doLookup(string req, int pid, int vpn);
    @(negedge clk);
    lkValid = 1'b1; lkPid = PW'(pid); lkVpn = VW'(vpn);
    #1;
    chk(req, "lkReady when idle", int'(lkReady), 1);
    @(posedge clk);
    @(negedge clk);
    lkValid = 1'b0;
    awaitResponse(req, pid, vpn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nIns;
    void'($urandom(32'd20240));
    for (int i = 0; i < 64; i++) mHead[i] = -1;
    for (int i = 0; i < NF; i++) begin mNext[i] = -1; mUsed[i] = 1'b0; mPid[i] = 0; mVpn[i] = 0; end
    rst_n = 1'b0; lkValid = 1'b0; insValid = 1'b0;
    lkPid = '0; lkVpn = '0; insPid = '0; insVpn = '0; insFrame = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1", "lkReady after reset", int'(lkReady), 1);
    chk("R1", "insReady after reset", int'(insReady), 1);
    chk("R1", "rspValid after reset", int'(rspValid), 0);
    doLookup("R1", 1, 'h00001);   // empty slot: miss in one cycle (R6)

    // Directed chain building in slot 1 (R2, R3, R5, R6, R7)
    doInsert(1, 'h00001, 5);
    doLookup("R4", 1, 'h00001);
    doLookup("R3", 2, 'h00001);   // same page, other process
    doInsert(1, 'h00400, 9);      // folds to slot 1 as well
    doLookup("R2", 1, 'h00400);   // newest at head: latency 1
    doLookup("R7", 1, 'h00001);   // older entry now at position 1
    doLookup("R6", 1, 'h00041);   // slot 1, no match: latency 3
    doInsert(1, 'h00001, 63);     // duplicate key in highest frame
    doLookup("R7", 1, 'h00001);   // most recent one is found

    // R9: insert and lookup raised together
    @(negedge clk);
    insValid = 1'b1; insPid = 8'd3; insVpn = 20'h12345; insFrame = 6'd20;
    lkValid = 1'b1;  lkPid = 8'd3;  lkVpn = 20'h12345;
    #1;
    chk("R9", "insReady with both valid", int'(insReady), 1);
    chk("R9", "lkReady held with both valid", int'(lkReady), 0);
    @(posedge clk);
    @(negedge clk);
    insValid = 1'b0;
    modelInsert(3, 'h12345, 20);
    #1;
    chk("R9", "lkReady after insert", int'(lkReady), 1);
    @(posedge clk);
    @(negedge clk);
    lkValid = 1'b0;
    awaitResponse("R9", 3, 'h12345);

    // Random inserts crowded into four slots
    nIns = 0;
    for (int f = 0; f < NF && nIns < 40; f++) begin
      if (!mUsed[f]) begin
        int hi, lo;
        hi = $urandom % 1024;
        lo = hi ^ ($urandom % 4);
        doInsert(1 + ($urandom % 4), (hi << 10) | lo, f);
        nIns++;
      end
    end

    // Random lookups: present keys and near misses
    for (int n = 0; n < 60; n++) begin
      int f;
      f = $urandom % NF;
      if (mUsed[f]) begin
        if ($urandom % 3 == 0) doLookup("R3", (mPid[f] % 4) + 5, mVpn[f]);
        else                   doLookup("R5", mPid[f], mVpn[f]);
      end else begin
        doLookup("R6", 1 + ($urandom % 4), $urandom % 1024);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule